// File: doc/BRIEF.md
# In-Order Retire Slot Queue

This block is the circular buffer that sits between dispatch and commit in an out-of-order core. Dispatch books a contiguous run of slots for each instruction, one slot per micro-op. Every instruction books at least one slot, and no instruction books more than the whole queue. The block hands back a token, which is the index of the first slot of the run. Execution units report completion by presenting that token, and completions may arrive in any order.

Each cycle the block looks at the oldest entries. It releases a prefix of them that have all completed, in program order, up to a per-cycle instruction limit. Each released instruction appears on its own lane with its instruction ID, and lane 0 carries the oldest. The slots those instructions held become free again at the next clock edge.

Queue depth, ID width, micro-op count width and the per-cycle retire limit are parameters. A limit of 0 means the queue may retire as many instructions per cycle as it holds.

Top module: `retire_slot_queue`

## Requirements
- R1: After a synchronous active-low reset, `free_slots` equals DEPTH, `rsv_token` is 0, `rsv_ready` is high and no `ret_valid` bit or error flag is set.
- R2: A reservation occupies max(1, min(`rsv_uops`, DEPTH)) slots. A count of 0 takes one slot, and a count above DEPTH takes DEPTH slots.
- R3: `rsv_token` always shows the next free slot index. After an accepted reservation it advances by the slot count, modulo DEPTH.
- R4: `rsv_ready` is high exactly when `free_slots` is at least the slot count of the presented request. A reservation presented while `rsv_ready` is low is ignored: the token and the free count do not change, and `err_rsv` is high in the following cycle.
- R5: `free_slots` changes one cycle after the event that causes it. It drops by the slot count of an accepted reservation, it rises by the slot counts of the instructions retired, and it applies the net of both when they happen in the same cycle.
- R6: An instruction marked executed retires in the cycle after its mark. Retirement is strictly in reservation order, so an unexecuted oldest entry holds back younger executed ones.
- R7: At most RETIRE_MAX instructions retire per cycle (0 means no limit). `ret_valid` is packed from lane 0 upward, and lane 0 is the oldest.
- R8: An `exe_token` that is DEPTH or more, that is not the first slot of a live entry, or whose entry is already executed is ignored. In each of these cases `err_exe` is high in the following cycle.
- R9: Lane k reports the retiring instruction's ID on `ret_id[k*ID_W +: ID_W]` while `ret_valid[k]` is high.
- R10: The slot indices, the head and the tail wrap modulo DEPTH, so a run of slots may straddle the end of the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rsv_valid | input | 1 | Reservation request |
| rsv_id | input | ID_W | Instruction ID to record |
| rsv_uops | input | UOP_W | Micro-op count of the instruction |
| rsv_ready | output | 1 | Enough free slots for the presented request |
| rsv_token | output | IDX_W | Start slot that a reservation would get |
| exe_valid | input | 1 | Execution-complete report |
| exe_token | input | IDX_W+1 | Token of the completed instruction |
| ret_valid | output | LANES | Per-lane retire strobe, lane 0 oldest |
| ret_id | output | LANES*ID_W | Per-lane retired instruction ID |
| free_slots | output | CNT_W | Number of unbooked slots |
| err_rsv | output | 1 | A reservation was refused last cycle |
| err_exe | output | 1 | An invalid execution report arrived last cycle |

## Verification
A table of reservations with micro-op counts of 0, 1, several, and more than the queue holds checks the slot normalisation and the token walk. The oversized request is refused once the queue no longer has room, which separates the capping from the refusal path.

The completions are then fed in a deliberately scrambled order, youngest first and oldest last. This shows that the oldest entry blocks retirement. It also shows that one completion can release a burst that is cut at the lane limit, with the remainder leaving in the next cycle.

Tokens pointing to the middle of a run, to an already executed entry, or beyond the depth check the refusal of bad completions. A run that straddles the end of the buffer, and a retire that coincides with a reservation, check the wrap-around and the net free-count update.

// File: rtl/rq_pkg.sv
// Package: shared helpers for the retire slot queue.
// Assumes depth is nonzero.
package rq_pkg;

    // Slot count booked for a given micro-op count: at least 1, at most depth.
    function automatic int unsigned slot_need(input int unsigned uops, input int unsigned depth);
        if (uops == 0)
            return 1;
        else if (uops > depth)
            return depth;
        else
            return uops;
    endfunction

endpackage

// File: rtl/rq_slot_store.sv
// Module: per-slot entry storage.
// Every slot holds a live flag, a done flag, an instruction ID and a slot count.
// Only the first slot of a run is marked live.
// Assumes that an allocation and a release never address the same slot in one cycle.
module rq_slot_store #(
    parameter int DEPTH = 16,
    parameter int ID_W  = 8,
    parameter int CNT_W = 5,
    parameter int IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_en,
    input  logic [IDX_W-1:0]       alloc_idx,
    input  logic [ID_W-1:0]        alloc_id,
    input  logic [CNT_W-1:0]       alloc_cnt,
    input  logic                   mark_en,
    input  logic [IDX_W-1:0]       mark_idx,
    input  logic [DEPTH-1:0]       release_mask,
    output logic [DEPTH-1:0]       live_o,
    output logic [DEPTH-1:0]       done_o,
    output logic [DEPTH*ID_W-1:0]  id_o,
    output logic [DEPTH*CNT_W-1:0] cnt_o
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Update one slot: allocation first, then release, then the execute mark.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_o[s]                 <= 1'b0;
                done_o[s]                 <= 1'b0;
                id_o[s*ID_W +: ID_W]      <= '0;
                cnt_o[s*CNT_W +: CNT_W]   <= '0;
            end else if (alloc_en && alloc_idx == IDX_W'(s)) begin
                live_o[s]                 <= 1'b1;
                done_o[s]                 <= 1'b0;
                id_o[s*ID_W +: ID_W]      <= alloc_id;
                cnt_o[s*CNT_W +: CNT_W]   <= alloc_cnt;
            end else if (release_mask[s]) begin
                live_o[s]                 <= 1'b0;
                done_o[s]                 <= 1'b0;
            end else if (mark_en && mark_idx == IDX_W'(s)) begin
                done_o[s]                 <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rq_pointers.sv
// Module: head pointer, tail pointer and free-slot counter.
// Assumes that alloc_cnt never exceeds free_o and that ret_cnt never exceeds the used slots.
module rq_pointers #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [CNT_W-1:0] alloc_cnt,
    input  logic [CNT_W-1:0] ret_cnt,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] tail_o,
    output logic [CNT_W-1:0] free_o
);
    localparam int SUM_W = IDX_W + 2;

    logic [SUM_W-1:0] head_sum, tail_sum;
    logic [CNT_W-1:0] alloc_eff;

    // Next head and tail positions, wrapped modulo DEPTH.
    always_comb begin
        alloc_eff = alloc_en ? alloc_cnt : '0;
        head_sum  = {2'b00, head_o} + SUM_W'(ret_cnt);
        if (head_sum >= SUM_W'(DEPTH)) head_sum = head_sum - SUM_W'(DEPTH);
        tail_sum  = {2'b00, tail_o} + SUM_W'(alloc_eff);
        if (tail_sum >= SUM_W'(DEPTH)) tail_sum = tail_sum - SUM_W'(DEPTH);
    end

    // Register the pointers and the net free count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_o <= '0;
            tail_o <= '0;
            free_o <= CNT_W'(DEPTH);
        end else begin
            head_o <= head_sum[IDX_W-1:0];
            tail_o <= tail_sum[IDX_W-1:0];
            free_o <= free_o + ret_cnt - alloc_eff;
        end
    end
endmodule

// File: rtl/rq_retire_walk.sv
// Module: combinational in-order retirement walk.
// Starting at the head, it follows the runs of slots and stops at the first unexecuted entry,
// at the lane limit, or when every used slot has been consumed.
// Assumes that the head always points at a live entry whenever used is nonzero.
module rq_retire_walk #(
    parameter int DEPTH = 16,
    parameter int ID_W  = 8,
    parameter int CNT_W = 5,
    parameter int IDX_W = 4,
    parameter int LANES = 4
) (
    input  logic [IDX_W-1:0]       head,
    input  logic [CNT_W-1:0]       used,
    input  logic [DEPTH-1:0]       live,
    input  logic [DEPTH-1:0]       done,
    input  logic [DEPTH*ID_W-1:0]  ids,
    input  logic [DEPTH*CNT_W-1:0] cnts,
    output logic [LANES-1:0]       lane_valid,
    output logic [LANES*ID_W-1:0]  lane_id,
    output logic [CNT_W-1:0]       slots_freed,
    output logic [DEPTH-1:0]       release_mask
);
    localparam int SUM_W = IDX_W + 2;

    logic [IDX_W-1:0] pos;
    logic [CNT_W-1:0] consumed;
    logic [CNT_W-1:0] c;
    logic [SUM_W-1:0] nxt;
    logic             go;

    // Walk the lanes from oldest to youngest.
    always_comb begin
        pos          = head;
        consumed     = '0;
        go           = 1'b1;
        lane_valid   = '0;
        lane_id      = '0;
        release_mask = '0;
        c            = '0;
        nxt          = '0;
        for (int k = 0; k < LANES; k++) begin
            c = cnts[pos*CNT_W +: CNT_W];
            if (go && consumed < used && live[pos] && done[pos]) begin
                lane_valid[k]             = 1'b1;
                lane_id[k*ID_W +: ID_W]   = ids[pos*ID_W +: ID_W];
                release_mask[pos]         = 1'b1;
                consumed                  = consumed + c;
                nxt                       = {2'b00, pos} + SUM_W'(c);
                if (nxt >= SUM_W'(DEPTH)) nxt = nxt - SUM_W'(DEPTH);
                pos                       = nxt[IDX_W-1:0];
            end else begin
                go = 1'b0;
            end
        end
        slots_freed = consumed;
    end
endmodule

// File: rtl/retire_slot_queue.sv
// Module: top level of the in-order retire slot queue.
// Reserves contiguous slot runs, accepts out-of-order execute marks and retires in order.
// Assumes DEPTH >= 2 and a UOP_W of at most 31 bits.
module retire_slot_queue #(
    parameter int DEPTH      = 16,
    parameter int ID_W       = 8,
    parameter int UOP_W      = 5,
    parameter int RETIRE_MAX = 4,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int LANES     = (RETIRE_MAX == 0 || RETIRE_MAX > DEPTH) ? DEPTH : RETIRE_MAX
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rsv_valid,
    input  logic [ID_W-1:0]       rsv_id,
    input  logic [UOP_W-1:0]      rsv_uops,
    output logic                  rsv_ready,
    output logic [IDX_W-1:0]      rsv_token,
    input  logic                  exe_valid,
    input  logic [IDX_W:0]        exe_token,
    output logic [LANES-1:0]      ret_valid,
    output logic [LANES*ID_W-1:0] ret_id,
    output logic [CNT_W-1:0]      free_slots,
    output logic                  err_rsv,
    output logic                  err_exe
);
    logic [CNT_W-1:0]       need_cnt;
    logic                   accept;
    logic                   exe_ok;
    logic [IDX_W-1:0]       exe_idx;
    logic [IDX_W-1:0]       head;
    logic [CNT_W-1:0]       freed;
    logic [DEPTH-1:0]       release_mask;
    logic [DEPTH-1:0]       live, done;
    logic [DEPTH*ID_W-1:0]  ids;
    logic [DEPTH*CNT_W-1:0] cnts;

    // Normalise the request, decide acceptance and qualify the execute report.
    always_comb begin
        need_cnt  = CNT_W'(rq_pkg::slot_need(32'(rsv_uops), DEPTH));
        rsv_ready = free_slots >= need_cnt;
        accept    = rsv_valid && rsv_ready;
        exe_idx   = exe_token[IDX_W-1:0];
        exe_ok    = exe_valid && (exe_token < (IDX_W+1)'(DEPTH))
                    && live[exe_idx] && !done[exe_idx];
    end

    rq_pointers #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) ptr_i (
        .clk(clk), .rst_n(rst_n), .alloc_en(accept), .alloc_cnt(need_cnt),
        .ret_cnt(freed), .head_o(head), .tail_o(rsv_token), .free_o(free_slots)
    );

    rq_slot_store #(.DEPTH(DEPTH), .ID_W(ID_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n), .alloc_en(accept), .alloc_idx(rsv_token),
        .alloc_id(rsv_id), .alloc_cnt(need_cnt), .mark_en(exe_ok), .mark_idx(exe_idx),
        .release_mask(release_mask), .live_o(live), .done_o(done), .id_o(ids), .cnt_o(cnts)
    );

    rq_retire_walk #(.DEPTH(DEPTH), .ID_W(ID_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .LANES(LANES)) walk_i (
        .head(head), .used(CNT_W'(DEPTH) - free_slots), .live(live), .done(done),
        .ids(ids), .cnts(cnts), .lane_valid(ret_valid), .lane_id(ret_id),
        .slots_freed(freed), .release_mask(release_mask)
    );

    // One-cycle error pulses for refused requests and bad execute reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_rsv <= 1'b0;
            err_exe <= 1'b0;
        end else begin
            err_rsv <= rsv_valid && !rsv_ready;
            err_exe <= exe_valid && !exe_ok;
        end
    end
endmodule

// File: rtl/rq_checker.sv
// Module: property checker for the retire slot queue, attached by bind.
// Observes the ports only.
module rq_checker #(
    parameter int DEPTH = 16,
    parameter int ID_W  = 8,
    parameter int UOP_W = 5,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rsv_valid,
    input logic [UOP_W-1:0] rsv_uops,
    input logic             rsv_ready,
    input logic [IDX_W-1:0] rsv_token,
    input logic             exe_valid,
    input logic [IDX_W:0]   exe_token,
    input logic [LANES-1:0] ret_valid,
    input logic [CNT_W-1:0] free_slots,
    input logic             err_rsv,
    input logic             err_exe
);
    p_reset_free_r1: assert property (@(posedge clk)
        !rst_n |=> free_slots == CNT_W'(DEPTH));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        free_slots <= CNT_W'(DEPTH));

    p_token_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid && rsv_ready) |=>
        32'(rsv_token) == (32'($past(rsv_token)) + rq_pkg::slot_need(32'($past(rsv_uops)), DEPTH)) % DEPTH);

    p_refuse_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid && !rsv_ready) |=> err_rsv);

    p_refuse_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid && !rsv_ready) |=> $stable(rsv_token));

    p_range_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_valid && exe_token >= (IDX_W+1)'(DEPTH)) |=> err_exe);

    p_lanes_packed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ret_valid + 1'b1) & ret_valid) == '0);

    p_retire_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid[0] |-> free_slots < CNT_W'(DEPTH));
endmodule

bind retire_slot_queue rq_checker #(
    .DEPTH(DEPTH), .ID_W(ID_W), .UOP_W(UOP_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .LANES(LANES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_uops(rsv_uops),
    .rsv_ready(rsv_ready), .rsv_token(rsv_token), .exe_valid(exe_valid),
    .exe_token(exe_token), .ret_valid(ret_valid), .free_slots(free_slots),
    .err_rsv(err_rsv), .err_exe(err_exe)
);

// File: tb/retire_slot_queue_tb_top.sv
`timescale 1ns/1ps
// Bench: a table-driven reservation walk, followed by directed retire and corner tests.
module retire_slot_queue_tb_top;
    localparam int DEPTH = 16, ID_W = 8, UOP_W = 5, RMAX = 4;
    localparam int IDX_W = 4, CNT_W = 5, LANES = 4;
    localparam int NV = 6;
    localparam int T_UOPS  [NV] = '{0, 2, 5, 1, 3, 31};
    localparam int T_SLOTS [NV] = '{1, 2, 5, 1, 3, 16};
    localparam int T_OK    [NV] = '{1, 1, 1, 1, 1, 0};

    logic clk = 0, rst_n = 0;
    logic rsv_valid = 0, exe_valid = 0;
    logic [ID_W-1:0] rsv_id = 0;
    logic [UOP_W-1:0] rsv_uops = 0;
    logic [IDX_W:0] exe_token = 0;
    logic rsv_ready, err_rsv, err_exe;
    logic [IDX_W-1:0] rsv_token;
    logic [LANES-1:0] ret_valid;
    logic [LANES*ID_W-1:0] ret_id;
    logic [CNT_W-1:0] free_slots;
    int n_chk = 0, n_bad = 0;
    int exp_tok, exp_free;
    bit finished = 0;

    always #10 clk = ~clk;

    retire_slot_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .UOP_W(UOP_W), .RETIRE_MAX(RMAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_id(rsv_id), .rsv_uops(rsv_uops),
        .rsv_ready(rsv_ready), .rsv_token(rsv_token), .exe_valid(exe_valid), .exe_token(exe_token),
        .ret_valid(ret_valid), .ret_id(ret_id), .free_slots(free_slots),
        .err_rsv(err_rsv), .err_exe(err_exe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one clock edge and land on the following falling edge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        rsv_valid = 0;
        exe_valid = 0;
    endtask

    task automatic rsv(input int id, input int uops);
        rsv_valid = 1; rsv_id = ID_W'(id); rsv_uops = UOP_W'(uops);
    endtask

    task automatic exe(input int tok);
        exe_valid = 1; exe_token = (IDX_W+1)'(tok);
    endtask

    function automatic int lane_id(input int k);
        return int'(ret_id[k*ID_W +: ID_W]);
    endfunction

    initial begin
        #3_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 free", int'(free_slots), DEPTH);
        check("R1 token", int'(rsv_token), 0);
        check("R1 ret_valid", int'(ret_valid), 0);
        check("R1 ready", int'(rsv_ready), 1);
        check("R1 errors", int'({err_rsv, err_exe}), 0);

        // Table walk: R2 slot normalisation, R3 token, R4 ready/refusal, R5 free count
        exp_tok = 0; exp_free = DEPTH;
        for (int i = 0; i < NV; i++) begin
            rsv(10 + i, T_UOPS[i]);
            #1;
            check("R4 ready", int'(rsv_ready), T_OK[i]);
            check("R3 token", int'(rsv_token), exp_tok);
            cyc();
            if (T_OK[i] != 0) begin
                exp_tok = (exp_tok + T_SLOTS[i]) % DEPTH;
                exp_free -= T_SLOTS[i];
            end
            check("R2 free after reserve", int'(free_slots), exp_free);
            check("R3 token step", int'(rsv_token), exp_tok);
            check("R4 err_rsv", int'(err_rsv), 1 - T_OK[i]);
        end
        // Entries now start at 0,1,3,8,9 with ids 10..14

        // R6: a younger entry done while the head is not done retires nothing
        exe(1); cyc();
        check("R8 good token no err", int'(err_exe), 0);
        check("R6 head blocks", int'(ret_valid), 0);
        // R8: bad execute reports
        exe(2); cyc(); check("R8 mid-run token", int'(err_exe), 1);
        exe(1); cyc(); check("R8 already executed", int'(err_exe), 1);
        exe(20); cyc(); check("R8 out of range", int'(err_exe), 1);
        check("R8 no retire side effect", int'(ret_valid), 0);
        // R6/R9: head done releases two in order
        exe(0); cyc();
        check("R6 two retire", int'(ret_valid), 3);
        check("R9 lane0 id", lane_id(0), 10);
        check("R9 lane1 id", lane_id(1), 11);
        cyc();
        check("R5 free after retire", int'(free_slots), 7);
        check("R6 nothing more", int'(ret_valid), 0);

        // R7: five completed entries, limit of four per cycle
        rsv(15, 1); #1; check("R3 token 12", int'(rsv_token), 12); cyc();
        rsv(16, 1); #1; check("R3 token 13", int'(rsv_token), 13); cyc();
        exe(13); cyc(); exe(12); cyc(); exe(9); cyc(); exe(8); cyc();
        check("R6 blocked by slot 3", int'(ret_valid), 0);
        exe(3); cyc();
        check("R7 four lanes", int'(ret_valid), 15);
        check("R9 lane0", lane_id(0), 12);
        check("R9 lane1", lane_id(1), 13);
        check("R9 lane2", lane_id(2), 14);
        check("R9 lane3", lane_id(3), 15);
        cyc();
        check("R7 remainder", int'(ret_valid), 1);
        check("R9 remainder id", lane_id(0), 16);
        check("R5 free mid", int'(free_slots), 15);
        cyc();
        check("R5 empty", int'(free_slots), 16);
        check("R7 idle", int'(ret_valid), 0);

        // R10: run straddling the end of the buffer
        rsv(20, 4); #1; check("R10 token 14", int'(rsv_token), 14); cyc();
        check("R10 wrapped tail", int'(rsv_token), 2);
        check("R5 free 12", int'(free_slots), 12);
        exe(14); cyc();
        check("R10 wrapped retire", int'(ret_valid), 1);
        check("R10 wrapped id", lane_id(0), 20);
        cyc();
        check("R10 free restored", int'(free_slots), 16);

        // R5: reserve and retire in the same cycle
        rsv(21, 2); cyc();
        exe(2); cyc();
        check("R6 ready to retire", int'(ret_valid), 1);
        rsv(22, 3); #1; check("R3 token 4", int'(rsv_token), 4);
        cyc();
        check("R5 net free", int'(free_slots), 13);
        check("R3 token 7", int'(rsv_token), 7);
        exe(4); cyc(); cyc();
        check("R5 final free", int'(free_slots), 16);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule